// File: doc/BRIEF.md
# Four-Wire Round-Robin Signal Multiplexer

This block carries a group of slow, mutually unsynchronised digital signals across a narrow cable. It does this by sampling each signal in turn on a fixed time-slot schedule. The sending end resynchronises every input to its own clock. On each rising edge it places one input's sample on a forward data wire, and it raises a frame-marker wire for the single cycle that carries slot 0. It also drives the link clock. The receiving end has no timing source of its own. It runs entirely from that link clock and samples the forward wire on the falling edge. It finds slot 0 from the marker and rebuilds each signal into its own held output register. A second data wire runs the other way and carries a smaller group of signals back to the sending end in the first slots of every frame.

The content of the signals is never interpreted. Serial buses, strobes and triggers all pass through as raw levels, and their edge timing is kept to within one frame period. A wider signal set fits by lengthening the frame and raising the link clock. With ten forward signals and a link clock of about 10 MHz, each signal is sampled at about 1 MHz. Both ends are placed in one top module here. The four link wires are brought out so that they can be observed.

Top module: `tdmLink`

## Requirements
- R1: While `rstN` is low, `linkSync`, `linkFwd`, `linkRev`, `fwdOut` and `revOut` are all 0.
- R2: `linkSync` is high for exactly one link clock in every `FRAME_LEN` cycles. The cycle it marks carries slot 0, and the slot number rises by one each cycle after it.
- R3: During slot k, `linkFwd` carries the resynchronised value of `fwdIn[k]` for k < `FWD_CNT` and carries 0 in any later slot.
- R4: At the falling edge inside slot k, `fwdOut[k]` takes the value on `linkFwd`. The change is visible before the rising edge that ends the slot, so the wire-to-output delay is under two link clocks.
- R5: `fwdOut[i]` changes only during slot i and holds its value for the rest of the frame.
- R6: A forward input that is held stable appears on its `fwdOut` bit within `FRAME_LEN`+3 clock cycles of the change.
- R7: During slot k, `linkRev` carries the resynchronised value of `revIn[k]` for k < `REV_CNT` and carries 0 in any later slot.
- R8: `revOut[j]` changes only at the rising edge that ends slot j. A stable `revIn` change appears on `revOut` within `FRAME_LEN`+3 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sending-end clock; also forwarded as the link clock |
| rstN | input | 1 | Asynchronous active-low reset for both ends |
| fwdIn | input | FWD_CNT | Asynchronous signals to carry forward |
| revIn | input | REV_CNT | Asynchronous signals to carry back, entering at the receiving end |
| fwdOut | output | FWD_CNT | Rebuilt forward signals at the receiving end |
| revOut | output | REV_CNT | Rebuilt reverse signals at the sending end |
| linkClk | output | 1 | Link clock wire |
| linkSync | output | 1 | Frame-marker wire, high during slot 0 |
| linkFwd | output | 1 | Forward data wire |
| linkRev | output | 1 | Reverse data wire |

## Verification
If the receiving slot counter is misaligned, samples land on the wrong outputs. This shows up within one frame as a `fwdOut` bit that changes outside its own slot or disagrees with the forward wire. If either counter drifts from the frame period, the marker arrives while the receiver expects a slot other than 0, and this is detectable at the very next marker. A wrong resynchroniser depth or a wrong capture edge shows as end-to-end latency beyond the stated bound, or as a reverse bit captured from the neighbouring slot. The bench tracks the slot number from the marker wire alone and compares every output against the wire value of the matching slot on every cycle.

// File: rtl/tdmPkg.sv
package tdmPkg;
  // Width of every slot number; frames up to 2**SLOT_BITS slots long.
  parameter int SLOT_BITS = 8;

  // Strobes handed from the sending-end control to its datapath.
  typedef struct packed {
    logic [SLOT_BITS-1:0] sendSlot;   // slot whose bit is loaded at the next rising edge
    logic [SLOT_BITS-1:0] lineSlot;   // slot currently on the wires
    logic                 frameStart; // next loaded slot is slot 0
    logic                 capEn;      // wires carry a valid slot
  } tdmStrobe_t;
endpackage

// File: rtl/tdmMasterCtrl.sv
module tdmMasterCtrl
  import tdmPkg::*;
#(
  parameter int FRAME_LEN = 10
) (
  input  logic       clk,
  input  logic       rstN,
  output tdmStrobe_t stb
);
  localparam logic [SLOT_BITS-1:0] LAST_SLOT = SLOT_BITS'(FRAME_LEN - 1);

  logic [SLOT_BITS-1:0] slot;
  logic [SLOT_BITS-1:0] lineSlot;
  logic                 lineValid;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      slot      <= '0;
      lineSlot  <= '0;
      lineValid <= 1'b0;
    end else begin
      slot      <= (slot == LAST_SLOT) ? '0 : slot + 1'b1;
      lineSlot  <= slot;
      lineValid <= 1'b1;
    end
  end

  always_comb begin
    stb.sendSlot   = slot;
    stb.lineSlot   = lineSlot;
    stb.frameStart = (slot == '0);
    stb.capEn      = lineValid;
  end

  // R2
  slot_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (slot <= LAST_SLOT));

  // R2
  sync_once_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.frameStart && FRAME_LEN > 1) |=> !stb.frameStart);
endmodule

// File: rtl/tdmMasterPath.sv
module tdmMasterPath
  import tdmPkg::*;
#(
  parameter int FWD_CNT = 10,
  parameter int REV_CNT = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  tdmStrobe_t         stb,
  input  logic [FWD_CNT-1:0] fwdIn,
  input  logic               linkRev,
  output logic               txData,
  output logic               txSync,
  output logic [REV_CNT-1:0] revOut
);
  logic [FWD_CNT-1:0] syncA;
  logic [FWD_CNT-1:0] syncB;
  logic               selBit;

  // Two-stage resynchroniser on every forward input.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= '0;
      syncB <= '0;
    end else begin
      syncA <= fwdIn;
      syncB <= syncA;
    end
  end

  // Slot selector; slots beyond the forward set read as 0.
  always_comb begin
    selBit = 1'b0;
    for (int i = 0; i < FWD_CNT; i++) begin
      if (stb.sendSlot == SLOT_BITS'(i)) selBit = syncB[i];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txData <= 1'b0;
      txSync <= 1'b0;
    end else begin
      txData <= selBit;
      txSync <= stb.frameStart;
    end
  end

  // Reverse capture at the edge that closes each reverse slot.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      revOut <= '0;
    end else begin
      for (int j = 0; j < REV_CNT; j++) begin
        if (stb.capEn && stb.lineSlot == SLOT_BITS'(j)) revOut[j] <= linkRev;
      end
    end
  end

  // R3
  fwd_pad_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.sendSlot >= SLOT_BITS'(FWD_CNT)) |=> !txData);

  // R8
  rev_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.capEn || stb.lineSlot >= SLOT_BITS'(REV_CNT)) |=> $stable(revOut));
endmodule

// File: rtl/tdmSlave.sv
module tdmSlave
  import tdmPkg::*;
#(
  parameter int FRAME_LEN = 10,
  parameter int FWD_CNT   = 10,
  parameter int REV_CNT   = 2
) (
  input  logic               linkClk,
  input  logic               rstN,
  input  logic               linkSync,
  input  logic               linkFwd,
  input  logic [REV_CNT-1:0] revIn,
  output logic               linkRev,
  output logic [FWD_CNT-1:0] fwdOut
);
  localparam logic [SLOT_BITS-1:0] LAST_SLOT = SLOT_BITS'(FRAME_LEN - 1);

  logic [SLOT_BITS-1:0] nextSlot;
  logic [SLOT_BITS-1:0] curSlot;
  logic                 locked;
  logic                 active;
  logic [REV_CNT-1:0]   revA;
  logic [REV_CNT-1:0]   revB;
  logic                 revBit;

  always_comb begin
    curSlot = linkSync ? '0 : nextSlot;
    active  = locked | linkSync;
    revBit  = 1'b0;
    for (int j = 0; j < REV_CNT; j++) begin
      if (curSlot == SLOT_BITS'(j)) revBit = revB[j];
    end
  end

  // Slot tracking and reverse drive, all on the falling link edge.
  always_ff @(negedge linkClk or negedge rstN) begin
    if (!rstN) begin
      nextSlot <= '0;
      locked   <= 1'b0;
      revA     <= '0;
      revB     <= '0;
      linkRev  <= 1'b0;
    end else begin
      revA    <= revIn;
      revB    <= revA;
      linkRev <= active ? revBit : 1'b0;
      if (active) begin
        locked   <= 1'b1;
        nextSlot <= (curSlot == LAST_SLOT) ? '0 : curSlot + 1'b1;
      end
    end
  end

  // One held register per rebuilt output.
  for (genvar i = 0; i < FWD_CNT; i++) begin : gOut
    always_ff @(negedge linkClk or negedge rstN) begin
      if (!rstN) begin
        fwdOut[i] <= 1'b0;
      end else if (active && curSlot == SLOT_BITS'(i)) begin
        fwdOut[i] <= linkFwd;
      end
    end

    // R5
    out_hold_chk: assert property (@(negedge linkClk) disable iff (!rstN)
      !(active && curSlot == SLOT_BITS'(i)) |=> $stable(fwdOut[i]));
  end

  // R2
  lock_align_chk: assert property (@(negedge linkClk) disable iff (!rstN)
    (locked && linkSync) |-> (nextSlot == '0));

  // R7
  rev_pad_chk: assert property (@(negedge linkClk) disable iff (!rstN)
    (active && curSlot >= SLOT_BITS'(REV_CNT)) |=> !linkRev);
endmodule

// File: rtl/tdmLink.sv
module tdmLink
  import tdmPkg::*;
#(
  parameter int FRAME_LEN = 10,
  parameter int FWD_CNT   = 10,
  parameter int REV_CNT   = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [FWD_CNT-1:0] fwdIn,
  input  logic [REV_CNT-1:0] revIn,
  output logic [FWD_CNT-1:0] fwdOut,
  output logic [REV_CNT-1:0] revOut,
  output logic               linkClk,
  output logic               linkSync,
  output logic               linkFwd,
  output logic               linkRev
);
  if (FRAME_LEN < FWD_CNT || FRAME_LEN < REV_CNT || FRAME_LEN > 2 ** SLOT_BITS) begin : gBadCfg
    $error("tdmLink: frame length does not fit the signal counts");
  end

  tdmStrobe_t stb;

  assign linkClk = clk;

  tdmMasterCtrl #(.FRAME_LEN(FRAME_LEN)) ctrl_i (
    .clk  (clk),
    .rstN (rstN),
    .stb  (stb)
  );

  tdmMasterPath #(.FWD_CNT(FWD_CNT), .REV_CNT(REV_CNT)) path_i (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .fwdIn   (fwdIn),
    .linkRev (linkRev),
    .txData  (linkFwd),
    .txSync  (linkSync),
    .revOut  (revOut)
  );

  tdmSlave #(.FRAME_LEN(FRAME_LEN), .FWD_CNT(FWD_CNT), .REV_CNT(REV_CNT)) slave_i (
    .linkClk  (linkClk),
    .rstN     (rstN),
    .linkSync (linkSync),
    .linkFwd  (linkFwd),
    .revIn    (revIn),
    .linkRev  (linkRev),
    .fwdOut   (fwdOut)
  );
endmodule

// File: tb/tdmLink_tb_top.sv
module tdmLink_tb_top;
  localparam int F   = 10;
  localparam int FWD = 10;
  localparam int REV = 2;

  logic           clk = 1'b0;
  logic           rstN = 1'b0;
  logic [FWD-1:0] fwdIn = '0;
  logic [REV-1:0] revIn = '0;
  logic [FWD-1:0] fwdOut;
  logic [REV-1:0] revOut;
  logic           linkClk, linkSync, linkFwd, linkRev;
  int             nChecks = 0;
  int             nFails = 0;
  logic [15:0]    lfsr = 16'hACE1;

  always #10 clk = ~clk;

  tdmLink #(.FRAME_LEN(F), .FWD_CNT(FWD), .REV_CNT(REV)) dut_i (
    .clk(clk), .rstN(rstN), .fwdIn(fwdIn), .revIn(revIn),
    .fwdOut(fwdOut), .revOut(revOut), .linkClk(linkClk),
    .linkSync(linkSync), .linkFwd(linkFwd), .linkRev(linkRev)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
  endtask

  // Sample point: shortly after the falling edge, inside the current slot.
  task automatic sampleStep();
    @(negedge clk);
    #5;
  endtask

  task automatic waitSync();
    for (int n = 0; n < 4 * F; n++) begin
      sampleStep();
      if (linkSync) return;
    end
    check(1'b0, "R2", "no frame marker seen", 0, 1);
  endtask

  task automatic stepLfsr();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  endtask

  task automatic testReset();
    rstN  = 1'b0;
    fwdIn = '1;
    revIn = '1;
    repeat (4) sampleStep();
    check(linkSync == 1'b0, "R1", "marker in reset", 32'(linkSync), 0);
    check(linkFwd == 1'b0, "R1", "forward wire in reset", 32'(linkFwd), 0);
    check(linkRev == 1'b0, "R1", "reverse wire in reset", 32'(linkRev), 0);
    check(fwdOut == '0, "R1", "fwdOut in reset", 32'(fwdOut), 0);
    check(revOut == '0, "R1", "revOut in reset", 32'(revOut), 0);
    rstN = 1'b1;
  endtask

  task automatic testSyncPeriod();
    waitSync();
    for (int f = 0; f < 3; f++) begin
      int gap;
      gap = 0;
      for (int n = 0; n < 2 * F; n++) begin
        sampleStep();
        gap++;
        if (linkSync) break;
      end
      check(gap == F, "R2", "marker period", 32'(gap), 32'(F));
    end
  endtask

  task automatic testSlotOrder(input logic [FWD-1:0] pat, input logic [REV-1:0] rpat);
    fwdIn = pat;
    revIn = rpat;
    repeat (F + 4) sampleStep();
    waitSync();
    for (int k = 0; k < F; k++) begin
      logic expF, expR;
      expF = (k < FWD) ? pat[k] : 1'b0;
      expR = (k < REV) ? rpat[k] : 1'b0;
      check(linkFwd == expF, "R3", $sformatf("forward slot %0d", k), 32'(linkFwd), 32'(expF));
      check(linkRev == expR, "R7", $sformatf("reverse slot %0d", k), 32'(linkRev), 32'(expR));
      check(linkSync == (k == 0), "R2", $sformatf("marker in slot %0d", k), 32'(linkSync), 32'(k == 0));
      if (k < F - 1) sampleStep();
    end
    check(fwdOut == pat, "R6", "rebuilt forward set", 32'(fwdOut), 32'(pat));
    sampleStep();
    check(revOut == rpat, "R8", "rebuilt reverse set", 32'(revOut), 32'(rpat));
  endtask

  task automatic testTransfer();
    int             slot;
    int             prevSlot;
    logic [FWD-1:0] prevF;
    logic [REV-1:0] prevR;
    waitSync();
    slot  = 0;
    prevF = fwdOut;
    prevR = revOut;
    for (int n = 0; n < 4 * F; n++) begin
      logic [FWD-1:0] maskF;
      logic [REV-1:0] maskR;
      stepLfsr();
      fwdIn = lfsr[FWD-1:0];
      revIn = lfsr[15:14];
      sampleStep();
      prevSlot = slot;
      slot = linkSync ? 0 : (slot + 1) % F;
      maskF = (slot < FWD) ? FWD'(1) << slot : '0;
      maskR = (prevSlot < REV) ? REV'(1) << prevSlot : '0;
      if (slot < FWD)
        check(fwdOut[slot] == linkFwd, "R4", $sformatf("slot %0d wire to output", slot),
              32'(fwdOut[slot]), 32'(linkFwd));
      check((fwdOut & ~maskF) == (prevF & ~maskF), "R5", $sformatf("hold outside slot %0d", slot),
            32'(fwdOut), 32'(prevF));
      check((revOut & ~maskR) == (prevR & ~maskR), "R8", $sformatf("reverse hold after slot %0d", prevSlot),
            32'(revOut), 32'(prevR));
      prevF = fwdOut;
      prevR = revOut;
    end
  endtask

  task automatic testLatency(input int idx, input int ridx, input logic val);
    @(posedge clk);
    #5;
    fwdIn[idx]  = val;
    revIn[ridx] = val;
    repeat (F + 3) @(posedge clk);
    #5;
    check(fwdOut[idx] == val, "R6", $sformatf("forward latency bit %0d", idx), 32'(fwdOut[idx]), 32'(val));
    check(revOut[ridx] == val, "R8", $sformatf("reverse latency bit %0d", ridx), 32'(revOut[ridx]), 32'(val));
  endtask

  initial begin
    #(20 * 150000);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    testReset();
    testSyncPeriod();
    testSlotOrder(10'b1010011001, 2'b10);
    testSlotOrder(10'b0101100110, 2'b01);
    testSlotOrder(10'b1000000001, 2'b11);
    testTransfer();
    fwdIn = '0;
    revIn = '0;
    repeat (2 * F) sampleStep();
    testLatency(0, 0, 1'b1);
    testLatency(FWD - 1, REV - 1, 1'b1);
    testLatency(0, 0, 1'b0);
    testLatency(FWD - 1, REV - 1, 1'b0);
    testLatency(4, 1, 1'b1);
    summary();
    $finish;
  end
endmodule